// File: doc/BRIEF.md
# Eight-Bit Bidirectional Universal Shift Register

This block holds a word in a row of edge-triggered flip-flops and, on each rising clock edge, either clears it, loads it in parallel, moves it one place toward the high bit, moves it one place toward the low bit, or keeps it. Two select inputs choose the operation, and an active-low synchronous clear overrides them. The stored word is offered to a shared data bus, split here into `bus_in`, `bus_out` and a drive enable `bus_oe`, so a pad ring or wrapper can tie the three to one bidirectional pin group. The same bus supplies the word taken in during a parallel load, and the drive enable drops by itself in that mode so the bus is free for the incoming data.

The lowest and highest bits are also always present on two dedicated serial outputs that are never switched off. Feeding one device's high serial output into the next device's right-shift serial input, and that device's low serial output back into the first device's left-shift serial input, chains several devices into one longer register that shifts in both directions.

Top module: `ushift_reg`

## Requirements
- R1: When `clr_n` is low at a rising clock edge, every stored bit becomes 0, whatever the select inputs are.
- R2: With `clr_n` high and `{sel1,sel0}` = 2'b11 (load), each stored bit n takes the value of `bus_in[n]` at the rising edge.
- R3: With `clr_n` high and `{sel1,sel0}` = 2'b01 (shift toward the high bit), `ser_in_r` enters bit 0 and each bit n moves to bit n+1; the old top bit is lost.
- R4: With `clr_n` high and `{sel1,sel0}` = 2'b10 (shift toward the low bit), `ser_in_l` enters the top bit and each bit n moves to bit n-1; the old bit 0 is lost.
- R5: With `clr_n` high and `{sel1,sel0}` = 2'b00, the stored word is unchanged.
- R6: `bus_out` always shows the stored word; `bus_oe` is 1 only when both `oe_a_n` and `oe_b_n` are low and `{sel1,sel0}` is not 2'b11.
- R7: Clear, load, shift and hold act the same whether `bus_oe` is high or low.
- R8: `ser_out_lo` always equals stored bit 0 and `ser_out_hi` always equals the top stored bit, independent of the output enables.
- R9: Two devices chained through their serial pins behave as one register of twice the width in both shift directions, including the bit crossing between devices.
- R10: The stored word changes only at rising clock edges; it is steady through the rest of the cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| clr_n | input | 1 | Synchronous clear, active low |
| sel0 | input | 1 | Operation select, low bit |
| sel1 | input | 1 | Operation select, high bit |
| ser_in_r | input | 1 | Serial bit entering bit 0 on a shift toward the high bit |
| ser_in_l | input | 1 | Serial bit entering the top bit on a shift toward the low bit |
| oe_a_n | input | 1 | Bus output enable A, active low |
| oe_b_n | input | 1 | Bus output enable B, active low |
| bus_in | input | WIDTH | Value sensed on the shared bus; parallel-load data |
| bus_out | output | WIDTH | Stored word offered to the shared bus |
| bus_oe | output | 1 | Bus drive enable; 0 means high impedance |
| ser_out_lo | output | 1 | Stored bit 0, always driven |
| ser_out_hi | output | 1 | Top stored bit, always driven |

## Verification
The bench drives a clear while the selects ask for a load, to catch a design that lets the mode win over the clear and leaves stale or bus data in place. It toggles the output enables during loads and shifts so that a design gating the register on the drive enable would freeze or lose data, and it checks that the drive enable falls in load mode even with both enables active, which a design that forgot the load interlock would fight on the bus. Two chained devices shift a marker across the device boundary both ways, exposing a swapped serial pin or a shift that drops or duplicates the crossing bit, and a long random run compares the joined word against a model of twice the width.

// File: rtl/ushift_pkg.sv
package ushift_pkg;

  // Operation codes, indexed as {sel1, sel0}
  typedef enum logic [1:0] {
    OP_KEEP  = 2'b00,
    OP_UP    = 2'b01,   // toward the high bit
    OP_DOWN  = 2'b10,   // toward the low bit
    OP_LOAD  = 2'b11
  } op_t;

  // Bus drive rule: both enables active and not in load
  function automatic logic drive_ok(input logic oe_a_n, input logic oe_b_n,
                                    input op_t op);
    return (!oe_a_n) && (!oe_b_n) && (op != OP_LOAD);
  endfunction

  // Per-bit next value from its own bit, its two neighbours and the load bit
  function automatic logic bit_next(input logic clr_n, input op_t op,
                                    input logic self, input logic below,
                                    input logic above, input logic ld);
    logic r;
    if (!clr_n) r = 1'b0;
    else begin
      unique case (op)
        OP_KEEP: r = self;
        OP_UP:   r = below;
        OP_DOWN: r = above;
        default: r = ld;
      endcase
    end
    return r;
  endfunction

endpackage

// File: rtl/ushift_op_dec.sv
module ushift_op_dec
  import ushift_pkg::*;
(
  input  logic clk,
  input  logic clr_n,
  input  logic sel0,
  input  logic sel1,
  input  logic oe_a_n,
  input  logic oe_b_n,
  output op_t  op,
  output logic load_evt,
  output logic drv_en
);

  assign op       = op_t'({sel1, sel0});
  assign load_evt = clr_n && (op == OP_LOAD);
  assign drv_en   = drive_ok(oe_a_n, oe_b_n, op);

  // R6: any inactive enable turns the bus drivers off
  p_oe_off_r6: assert property (@(posedge clk) disable iff (!clr_n)
    (oe_a_n || oe_b_n) |-> !drv_en);

  // R6: load select frees the bus
  p_load_hiz_r6: assert property (@(posedge clk) disable iff (!clr_n)
    (sel0 && sel1) |-> !drv_en);

endmodule

// File: rtl/ushift_core.sv
module ushift_core
  import ushift_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             clr_n,
  input  op_t              op,
  input  logic             ser_in_r,
  input  logic             ser_in_l,
  input  logic [WIDTH-1:0] ld_data,
  output logic [WIDTH-1:0] q
);

  localparam int TOP = WIDTH - 1;

  logic [WIDTH-1:0] d;
  logic [WIDTH-1:0] below_w;
  logic [WIDTH-1:0] above_w;

  // Neighbour wiring, one pair per bit
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    if (i == 0) begin : g_lo
      assign below_w[i] = ser_in_r;
    end else begin : g_lo_mid
      assign below_w[i] = q[i-1];
    end
    if (i == TOP) begin : g_hi
      assign above_w[i] = ser_in_l;
    end else begin : g_hi_mid
      assign above_w[i] = q[i+1];
    end
    assign d[i] = bit_next(clr_n, op, q[i], below_w[i], above_w[i], ld_data[i]);
  end

  always_ff @(posedge clk) begin
    q <= d;
  end

  // R1: clear wins over any select
  p_clear_r1: assert property (@(posedge clk)
    !clr_n |=> (q == '0));

  // R2: load takes the bus word
  p_load_r2: assert property (@(posedge clk) disable iff (!clr_n)
    (op == OP_LOAD) |=> (q == $past(ld_data)));

  // R3: shift toward the high bit
  p_up_r3: assert property (@(posedge clk) disable iff (!clr_n)
    (op == OP_UP) |=> (q[0] == $past(ser_in_r)) && (q[TOP:1] == $past(q[TOP-1:0])));

  // R4: shift toward the low bit
  p_down_r4: assert property (@(posedge clk) disable iff (!clr_n)
    (op == OP_DOWN) |=> (q[TOP] == $past(ser_in_l)) && (q[TOP-1:0] == $past(q[TOP:1])));

  // R5: keep
  p_keep_r5: assert property (@(posedge clk) disable iff (!clr_n)
    (op == OP_KEEP) |=> $stable(q));

endmodule

// File: rtl/ushift_reg.sv
module ushift_reg
  import ushift_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             sel0,
  input  logic             sel1,
  input  logic             ser_in_r,
  input  logic             ser_in_l,
  input  logic             oe_a_n,
  input  logic             oe_b_n,
  input  logic [WIDTH-1:0] bus_in,
  output logic [WIDTH-1:0] bus_out,
  output logic             bus_oe,
  output logic             ser_out_lo,
  output logic             ser_out_hi
);

  localparam int TOP = WIDTH - 1;

  op_t              op;
  logic             load_evt;
  logic             drv_en;
  logic [WIDTH-1:0] q;

  ushift_op_dec u_dec (
    .clk      (clk),
    .clr_n    (clr_n),
    .sel0     (sel0),
    .sel1     (sel1),
    .oe_a_n   (oe_a_n),
    .oe_b_n   (oe_b_n),
    .op       (op),
    .load_evt (load_evt),
    .drv_en   (drv_en)
  );

  ushift_core #(.WIDTH(WIDTH)) u_core (
    .clk      (clk),
    .clr_n    (clr_n),
    .op       (op),
    .ser_in_r (ser_in_r),
    .ser_in_l (ser_in_l),
    .ld_data  (bus_in),
    .q        (q)
  );

  assign bus_out    = q;
  assign bus_oe     = drv_en;
  assign ser_out_lo = q[0];
  assign ser_out_hi = q[TOP];

  // R7: a load with drivers off still captures the bus
  p_load_undriven_r7: assert property (@(posedge clk) disable iff (!clr_n)
    load_evt |=> (bus_out == $past(bus_in)));

  // R8: the serial taps never disagree with the bus word's end bits
  p_serial_r8: assert property (@(posedge clk)
    (ser_out_lo == bus_out[0]) && (ser_out_hi == bus_out[TOP]));

endmodule

// File: tb/ushift_reg_test.sv
module ushift_reg_test;

  localparam int W  = 8;
  localparam int W2 = 2 * W;

  logic clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  logic clr_n, sel0, sel1, sin_r, sin_l, oe_a_n, oe_b_n;
  logic [W2-1:0] din;
  logic [W-1:0]  out_lo, out_hi;
  logic oe_lo, oe_hi;
  logic so_lo_lo, so_lo_hi, so_hi_lo, so_hi_hi;

  int checks = 0;
  int errors = 0;
  logic [W2-1:0] exp_q;
  bit done = 1'b0;

  // lower device: bits 0..7
  ushift_reg #(.WIDTH(W)) uut (
    .clk(clk), .clr_n(clr_n), .sel0(sel0), .sel1(sel1),
    .ser_in_r(sin_r), .ser_in_l(so_hi_lo),
    .oe_a_n(oe_a_n), .oe_b_n(oe_b_n),
    .bus_in(din[W-1:0]), .bus_out(out_lo), .bus_oe(oe_lo),
    .ser_out_lo(so_lo_lo), .ser_out_hi(so_lo_hi)
  );

  // upper device: bits 8..15
  ushift_reg #(.WIDTH(W)) uut_hi (
    .clk(clk), .clr_n(clr_n), .sel0(sel0), .sel1(sel1),
    .ser_in_r(so_lo_hi), .ser_in_l(sin_l),
    .oe_a_n(oe_a_n), .oe_b_n(oe_b_n),
    .bus_in(din[W2-1:W]), .bus_out(out_hi), .bus_oe(oe_hi),
    .ser_out_lo(so_hi_lo), .ser_out_hi(so_hi_hi)
  );

  function automatic logic [W2-1:0] model(input logic [W2-1:0] cur,
      input logic c_n, input logic s1, input logic s0,
      input logic r, input logic l, input logic [W2-1:0] ld);
    logic [W2-1:0] m;
    if (!c_n) m = '0;
    else if (s1 && s0) m = ld;
    else if (s0) m = (cur << 1) | W2'(r);
    else if (s1) m = (cur >> 1) | (W2'(l) << (W2 - 1));
    else m = cur;
    return m;
  endfunction

  function automatic logic exp_oe(input logic a, input logic b,
                                  input logic s1, input logic s0);
    return (a == 1'b0) && (b == 1'b0) && !(s1 == 1'b1 && s0 == 1'b1);
  endfunction

  task automatic chk(input string tag, input logic [W2-1:0] act,
                     input logic [W2-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // drive at negedge, check enables, clock, check state after edge
  task automatic step(input logic c, input logic s1, input logic s0,
                      input logic r, input logic l, input logic a,
                      input logic b, input logic [W2-1:0] d, input string tag);
    @(negedge clk);
    chk("R10 steady", {out_hi, out_lo}, exp_q);
    clr_n = c; sel1 = s1; sel0 = s0; sin_r = r; sin_l = l;
    oe_a_n = a; oe_b_n = b; din = d;
    #1;
    chk("R6 bus_oe", W2'({oe_hi, oe_lo}), W2'({2{exp_oe(a, b, s1, s0)}}));
    @(posedge clk);
    exp_q = model(exp_q, c, s1, s0, r, l, d);
    #2;
    chk(tag, {out_hi, out_lo}, exp_q);
    chk("R8 serial",
        W2'({so_hi_hi, so_hi_lo, so_lo_hi, so_lo_lo}),
        W2'({exp_q[W2-1], exp_q[W], exp_q[W-1], exp_q[0]}));
  endtask

  initial begin
    #150000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7881));
    clr_n = 1'b0; sel0 = 1'b0; sel1 = 1'b0; sin_r = 1'b0; sin_l = 1'b0;
    oe_a_n = 1'b1; oe_b_n = 1'b1; din = '0;
    @(posedge clk);
    exp_q = '0;
    // R1: reset state
    step(1'b0, 1'b0, 1'b0, 0, 0, 0, 0, '0, "R1 reset");
    // R2: load with drivers requested on (R6 interlock keeps them off)
    step(1'b1, 1'b1, 1'b1, 0, 0, 0, 0, 16'hA5C3, "R2 load");
    // R5: hold
    step(1'b1, 1'b0, 1'b0, 1, 1, 0, 0, 16'hFFFF, "R5 hold");
    // R1: clear overrides load select
    step(1'b0, 1'b1, 1'b1, 1, 1, 0, 0, 16'hFFFF, "R1 clear over load");
    // R9/R3: marker crosses device boundary toward the high bit
    step(1'b1, 1'b1, 1'b1, 0, 0, 1, 0, 16'h0040, "R7 load drivers off");
    for (int k = 0; k < 3; k++)
      step(1'b1, 1'b0, 1'b1, 0, 0, 0, 0, '0, "R9 R3 cross up");
    // R4/R9: back down across the boundary
    for (int k = 0; k < 4; k++)
      step(1'b1, 1'b1, 1'b0, 0, 1, 0, 1, '0, "R9 R4 cross down");
    // R7: shifts with drivers off
    step(1'b1, 1'b0, 1'b1, 1, 0, 1, 1, '0, "R7 R3 shift undriven");
    step(1'b1, 1'b1, 1'b0, 0, 1, 1, 0, '0, "R7 R4 shift undriven");
    // random mix
    for (int k = 0; k < 400; k++) begin
      logic c;
      c = ($urandom % 16) != 0;
      step(c, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
           1'($urandom), 1'($urandom), 16'($urandom), "R9 random");
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule